// File: doc/BRIEF.md
# IR Pulse-Data Envelope Generator

This block forms the baseband envelope of an infrared remote-control transmitter. A free-running up-counter advances once per cycle in which the `tick` input is high. Each symbol starts at count 0. The output stays at its active level until the counter reaches the active-pulse length. It then stays inactive until the counter reaches the data-bit length. At that point the counter returns to 0 and the next symbol begins. Carrier generation and modulation sit outside this block.

Software drives the block through a small write-only register port. It sets run, repeat or one-shot operation, compare buffering, output polarity and a self-clearing software reset. It also writes the two lengths, the interrupt enables and the write-one-to-clear interrupt flags. When buffering is on, the two lengths pass through shadow copies that reload only at the end of a symbol. This lets software queue the next symbol while the current one is still being sent. A busy flag per length shows a write that is still waiting for the reload. Run, busy and flag state are brought out as plain status outputs.

Top module: `irtx_envgen`

## Requirements
- R1: Writing the run bit starts a symbol at count 0. While running, after k ticks the count is k modulo (DB+1), where DB is the active data-bit length. With AP ≤ DB, the output is at its active level exactly while the count is at most AP. When AP equals DB, the symbol ends on the data-bit match and the output stays active for the whole symbol.
- R2: The counter advances only on clock cycles where `tick` is 1. With `tick` low the count and the output hold.
- R3: With buffer enable 0, the compares use the length registers directly. A register write is in force from the next tick onward, including in the middle of a symbol.
- R4: With buffer enable 1, the compares use shadow copies of both lengths. The shadows load from the registers on the tick that matches the data-bit shadow, and they also load on every cycle while the block is stopped. A mid-symbol write therefore takes effect from the following symbol.
- R5: With buffer enable 1, writing a length sets its busy flag. The flag returns to 0 when that value is copied into its shadow. With buffer enable 0, both busy flags read 0.
- R6: The AP flag sets on a tick where the count equals the active AP compare value. The DB flag sets on a tick where the count equals the active DB compare value.
- R7: Writing 1 to a flag bit clears that flag, and writing 1 to the software-reset bit clears both flags. If a match and a write-one-to-clear happen in the same cycle, the flag stays set.
- R8: `irq` is 1 exactly while at least one flag is set together with its enable bit.
- R9: In one-shot mode, the first data-bit match clears the run bit and stops the counter. The `running` output follows the run bit.
- R10: The inactive and idle output level equals the invert bit, and the active level is its complement.
- R11: The software reset clears the counter, the run bit, both flags, both busy flags and the shadows, and returns the output to idle. The length and enable registers keep their values.
- R12: The write port uses these addresses. Address 0 is control: bit0 run, bit1 one-shot, bit2 buffer enable, bit3 invert, bit4 software reset (self-clearing). Address 1 is AP and address 2 is DB. Address 3 holds the enables and address 4 the flags, both with bit0 for AP and bit1 for DB.
- R13: If a compare value is lowered below the current count, the counter runs on, wraps modulo 2^CNT_W and ends the symbol when it next reaches the data-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one prescaled step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| data_out | output | 1 | Envelope output |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Counter running status |
| ap_busy | output | 1 | AP write waiting for shadow reload |
| db_busy | output | 1 | DB write waiting for shadow reload |
| ap_flag | output | 1 | AP match flag |
| db_flag | output | 1 | DB match flag |

## Verification
The bench builds the block with an 8-bit counter and with the shadow-buffer variant present. Toggling the enable bit therefore reaches both the direct and the buffered compare paths. The narrow counter brings the wrap past the top count within a few hundred cycles, so the case where a lowered data-bit length lets the count run around is checked end to end. Short lengths keep every symbol, match, reload and one-shot stop within a handful of ticks.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_APLEN = 3'd1,
      A_DBLEN = 3'd2,
      A_IEN   = 3'd3,
      A_FLAG  = 3'd4
   } reg_addr_e;

   localparam int B_RUN     = 0;
   localparam int B_ONESHOT = 1;
   localparam int B_BUFEN   = 2;
   localparam int B_INV     = 3;
   localparam int B_SWRST   = 4;

   localparam int N_FLAG = 2;
   localparam int F_AP   = 0;
   localparam int F_DB   = 1;

   typedef struct packed {
      logic invert;
      logic buf_en;
      logic one_shot;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/irtx_regs.sv
module irtx_regs
   import irtx_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_BUF = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [CNT_W-1:0]       wr_data,
   input  logic                   db_hit,
   input  logic                   stop_req,
   output ctrl_t                  ctrl,
   output logic                   sw_rst,
   output logic [CNT_W-1:0]       ap_cmp,
   output logic [CNT_W-1:0]       db_cmp,
   output logic                   ap_busy,
   output logic                   db_busy,
   output logic [N_FLAG-1:0]      ien,
   output logic [N_FLAG-1:0]      flag_clr
);
   logic sel_ctrl, sel_ap, sel_db, sel_ien, sel_flag;
   logic [CNT_W-1:0] ap_reg, db_reg;

   assign sel_ctrl = wr_en && (wr_addr == A_CTRL);
   assign sel_ap   = wr_en && (wr_addr == A_APLEN);
   assign sel_db   = wr_en && (wr_addr == A_DBLEN);
   assign sel_ien  = wr_en && (wr_addr == A_IEN);
   assign sel_flag = wr_en && (wr_addr == A_FLAG);

   assign sw_rst   = sel_ctrl && wr_data[B_SWRST];
   assign flag_clr = sel_flag ? wr_data[N_FLAG-1:0] : '0;

   // control: hardware stop has priority over a software run write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (sel_ctrl) begin
            ctrl.run      <= wr_data[B_RUN] && !wr_data[B_SWRST];
            ctrl.one_shot <= wr_data[B_ONESHOT];
            ctrl.buf_en   <= wr_data[B_BUFEN];
            ctrl.invert   <= wr_data[B_INV];
         end
         if (stop_req) ctrl.run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ap_reg <= '0;
         db_reg <= '0;
         ien    <= '0;
      end else begin
         if (sel_ap)  ap_reg <= wr_data;
         if (sel_db)  db_reg <= wr_data;
         if (sel_ien) ien    <= wr_data[N_FLAG-1:0];
      end
   end

   generate
      if (HAS_BUF) begin : g_buf
         logic [CNT_W-1:0] ap_sh, db_sh;
         logic             ap_bsy, db_bsy;
         logic             load;

         // reload at end of symbol, track registers while stopped
         assign load = db_hit || !ctrl.run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ap_sh <= '0;
               db_sh <= '0;
            end else if (sw_rst) begin
               ap_sh <= '0;
               db_sh <= '0;
            end else if (load) begin
               ap_sh <= ap_reg;
               db_sh <= db_reg;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ap_bsy <= 1'b0;
               db_bsy <= 1'b0;
            end else if (sw_rst || !ctrl.buf_en) begin
               ap_bsy <= 1'b0;
               db_bsy <= 1'b0;
            end else begin
               if (sel_ap)    ap_bsy <= 1'b1;
               else if (load) ap_bsy <= 1'b0;
               if (sel_db)    db_bsy <= 1'b1;
               else if (load) db_bsy <= 1'b0;
            end
         end

         assign ap_cmp  = ctrl.buf_en ? ap_sh : ap_reg;
         assign db_cmp  = ctrl.buf_en ? db_sh : db_reg;
         assign ap_busy = ap_bsy;
         assign db_busy = db_bsy;
      end else begin : g_direct
         assign ap_cmp  = ap_reg;
         assign db_cmp  = db_reg;
         assign ap_busy = 1'b0;
         assign db_busy = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irtx_counter.sv
module irtx_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             one_shot,
   input  logic             tick,
   input  logic             sw_rst,
   input  logic [CNT_W-1:0] ap_cmp,
   input  logic [CNT_W-1:0] db_cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             ap_hit,
   output logic             db_hit,
   output logic             stop_req,
   output logic             active
);
   logic adv;
   logic phase;

   assign adv      = run && tick;
   assign ap_hit   = adv && (cnt == ap_cmp);
   assign db_hit   = adv && (cnt == db_cmp);
   assign stop_req = db_hit && one_shot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b1;
      end else if (sw_rst || !run) begin
         cnt   <= '0;
         phase <= 1'b1;
      end else if (db_hit) begin
         cnt   <= '0;
         phase <= 1'b1;
      end else if (adv) begin
         cnt <= cnt + 1'b1;
         if (ap_hit) phase <= 1'b0;
      end
   end

   assign active = run && phase;
endmodule

// File: rtl/irtx_irq.sv
module irtx_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] ien,
   input  logic         sw_rst,
   output logic [N-1:0] flags,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      f <= 1'b0;
         else if (sw_rst) f <= 1'b0;
         else if (set[i]) f <= 1'b1;
         else if (clr[i]) f <= 1'b0;
      end
      assign flags[i] = f;
   end

   assign irq = |(flags & ien);
endmodule

// File: rtl/irtx_envgen.sv
module irtx_envgen
   import irtx_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_BUF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             data_out,
   output logic             irq,
   output logic             running,
   output logic             ap_busy,
   output logic             db_busy,
   output logic             ap_flag,
   output logic             db_flag
);
   generate
      if (CNT_W < 5 || CNT_W > 32) begin : g_bad_width
         $error("irtx_envgen: CNT_W must lie in 5..32");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              sw_rst;
   logic [CNT_W-1:0]  ap_cmp, db_cmp;
   logic [CNT_W-1:0]  cnt;
   logic              ap_hit, db_hit, stop_req, active;
   logic              one_shot;
   logic [N_FLAG-1:0] ien, flag_clr, flag_set, flags;

   irtx_regs #(.CNT_W(CNT_W), .HAS_BUF(HAS_BUF)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .db_hit   (db_hit),
      .stop_req (stop_req),
      .ctrl     (ctrl),
      .sw_rst   (sw_rst),
      .ap_cmp   (ap_cmp),
      .db_cmp   (db_cmp),
      .ap_busy  (ap_busy),
      .db_busy  (db_busy),
      .ien      (ien),
      .flag_clr (flag_clr)
   );

   assign one_shot = ctrl.one_shot;

   irtx_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl.run),
      .one_shot (one_shot),
      .tick     (tick),
      .sw_rst   (sw_rst),
      .ap_cmp   (ap_cmp),
      .db_cmp   (db_cmp),
      .cnt      (cnt),
      .ap_hit   (ap_hit),
      .db_hit   (db_hit),
      .stop_req (stop_req),
      .active   (active)
   );

   assign flag_set[F_AP] = ap_hit;
   assign flag_set[F_DB] = db_hit;

   irtx_irq #(.N(N_FLAG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (flag_set),
      .clr    (flag_clr),
      .ien    (ien),
      .sw_rst (sw_rst),
      .flags  (flags),
      .irq    (irq)
   );

   assign ap_flag  = flags[F_AP];
   assign db_flag  = flags[F_DB];
   assign running  = ctrl.run;
   assign data_out = ctrl.invert ^ active;
endmodule

// File: rtl/irtx_envgen_chk.sv
module irtx_envgen_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic             sw_rst,
   input logic             running,
   input logic             one_shot,
   input logic             ap_hit,
   input logic             db_hit,
   input logic [CNT_W-1:0] cnt,
   input logic             ap_busy,
   input logic             db_busy,
   input logic             ap_flag,
   input logic             db_flag,
   input logic             irq
);
   // R1: a data-bit match restarts the symbol at zero
   a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      db_hit |=> (cnt == '0));

   // R2: without a tick the count holds
   a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick && !sw_rst) |=> (cnt == $past(cnt)));

   // R5: reload empties the busy flags when no new write arrives
   a_r5_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (db_hit && !wr_en) |=> (!ap_busy && !db_busy));

   // R6: matches raise their flags
   a_r6_ap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_hit && !sw_rst) |=> ap_flag);
   a_r6_db_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (db_hit && !sw_rst) |=> db_flag);

   // R8: a request needs a pending flag
   a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ap_flag || db_flag));

   // R9: one-shot stops after its symbol
   a_r9_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (db_hit && one_shot) |=> !running);

   // R11: software reset returns the block to idle
   a_r11_swrst: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (cnt == '0 && !running && !ap_flag && !db_flag
                  && !ap_busy && !db_busy));
endmodule

bind irtx_envgen irtx_envgen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_en    (wr_en),
   .sw_rst   (sw_rst),
   .running  (running),
   .one_shot (one_shot),
   .ap_hit   (ap_hit),
   .db_hit   (db_hit),
   .cnt      (cnt),
   .ap_busy  (ap_busy),
   .db_busy  (db_busy),
   .ap_flag  (ap_flag),
   .db_flag  (db_flag),
   .irq      (irq)
);

// File: tb/tb_irtx_envgen.sv
`timescale 1ns/1ps
module tb_irtx_envgen;
   localparam int CW = 8;
   localparam logic [2:0] AD_CTRL = 3'd0, AD_AP = 3'd1, AD_DB = 3'd2,
                          AD_IEN = 3'd3, AD_FLAG = 3'd4;
   localparam logic [CW-1:0] C_RUN = 8'h01, C_ONE = 8'h02, C_BUF = 8'h04,
                             C_INV = 8'h08, C_RST = 8'h10;

   typedef struct packed {
      logic [7:0] ap;
      logic [7:0] db;
      logic       inv;
      logic [7:0] n;
      logic       exp;
   } vec_t;

   // symbol shape vectors: ap, db, invert, ticks after run, expected output
   localparam vec_t VECS [9] = '{
      '{8'd2, 8'd5, 1'b0, 8'd2,  1'b1},
      '{8'd2, 8'd5, 1'b0, 8'd3,  1'b0},
      '{8'd2, 8'd5, 1'b0, 8'd6,  1'b1},
      '{8'd2, 8'd5, 1'b1, 8'd4,  1'b1},
      '{8'd0, 8'd3, 1'b0, 8'd1,  1'b0},
      '{8'd0, 8'd3, 1'b0, 8'd4,  1'b1},
      '{8'd4, 8'd9, 1'b1, 8'd3,  1'b0},
      '{8'd7, 8'd7, 1'b0, 8'd7,  1'b1},
      '{8'd3, 8'd5, 1'b0, 8'd11, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic data_out, irq, running, ap_busy, db_busy, ap_flag, db_flag;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irtx_envgen #(.CNT_W(CW), .HAS_BUF(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .data_out(data_out),
      .irq(irq), .running(running), .ap_busy(ap_busy),
      .db_busy(db_busy), .ap_flag(ap_flag), .db_flag(db_flag)
   );

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start(input logic [CW-1:0] ap, input logic [CW-1:0] db,
                        input logic [CW-1:0] mode);
      wr(AD_CTRL, C_RST);
      wr(AD_AP, ap);
      wr(AD_DB, db);
      wr(AD_CTRL, mode | C_RUN);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R10 idle level, R12 register defaults)
      chk("R10 reset out", data_out, 0);
      chk("R12 reset irq", irq, 0);
      chk("R9 reset running", running, 0);
      chk("R5 reset busy", {ap_busy, db_busy}, 0);
      chk("R6 reset flags", {ap_flag, db_flag}, 0);

      // R1 / R10 symbol shape table
      foreach (VECS[i]) begin
         start(VECS[i].ap, VECS[i].db, VECS[i].inv ? C_INV : '0);
         ticks(int'(VECS[i].n));
         chk($sformatf("R1 vector %0d out", i), data_out, VECS[i].exp);
      end

      // R6 R7 R8 flags and request
      wr(AD_IEN, 8'h01);
      start(8'd2, 8'd5, '0);
      ticks(2);
      chk("R6 ap flag before match", ap_flag, 0);
      chk("R8 irq before match", irq, 0);
      ticks(1);
      chk("R6 ap flag at match", ap_flag, 1);
      chk("R8 irq enabled ap", irq, 1);
      ticks(3);
      chk("R6 db flag at match", db_flag, 1);
      wr(AD_CTRL, '0);
      chk("R9 running after stop write", running, 0);
      wr(AD_FLAG, 8'h01);
      chk("R7 w1c ap", ap_flag, 0);
      chk("R7 w1c leaves db", db_flag, 1);
      chk("R8 irq db not enabled", irq, 0);
      wr(AD_IEN, 8'h02);
      chk("R8 irq db enabled", irq, 1);
      wr(AD_CTRL, C_RST);
      chk("R7 swrst clears db", db_flag, 0);
      chk("R8 irq after swrst", irq, 0);
      wr(AD_IEN, 8'h00);

      // R9 one-shot with R10 inversion
      start(8'd1, 8'd3, C_ONE | C_INV);
      ticks(1);
      chk("R10 inverted active", data_out, 0);
      ticks(2);
      chk("R9 running mid symbol", running, 1);
      ticks(1);
      chk("R9 stopped after symbol", running, 0);
      chk("R10 inverted idle", data_out, 1);
      ticks(6);
      chk("R9 stays stopped", running, 0);
      chk("R9 idle holds", data_out, 1);

      // R2 tick gating
      start(8'd1, 8'd5, '0);
      tick = 1'b0;
      ticks(10);
      chk("R2 no count without tick", data_out, 1);
      tick = 1'b1;
      ticks(2);
      chk("R2 counts with tick", data_out, 0);

      // R3 unbuffered compare follows register at once
      start(8'd3, 8'd9, '0);
      ticks(2);
      wr(AD_AP, 8'd1);
      chk("R5 no busy unbuffered", ap_busy, 0);
      ticks(1);
      chk("R3 direct ap change", data_out, 1);

      // R4 R5 buffered compare
      start(8'd1, 8'd3, C_BUF);
      wr(AD_AP, 8'd2);
      wr(AD_DB, 8'd5);
      chk("R4 old ap in force", data_out, 0);
      chk("R5 busy after writes", {ap_busy, db_busy}, 2'b11);
      ticks(1);
      chk("R5 busy until reload", {ap_busy, db_busy}, 2'b11);
      ticks(1);
      chk("R5 busy cleared at reload", {ap_busy, db_busy}, 2'b00);
      chk("R4 new symbol starts", data_out, 1);
      ticks(2);
      chk("R4 new ap used", data_out, 1);
      ticks(3);
      chk("R4 new db used inactive", data_out, 0);
      ticks(1);
      chk("R4 new db wrap", data_out, 1);

      // R11 software reset mid run
      wr(AD_AP, 8'd4);
      chk("R5 busy on buffered write", ap_busy, 1);
      wr(AD_CTRL, C_RST | C_BUF);
      chk("R11 busy cleared", {ap_busy, db_busy}, 0);
      chk("R11 run cleared", running, 0);
      chk("R11 flags cleared", {ap_flag, db_flag}, 0);
      chk("R11 output idle", data_out, 0);

      // R13 wrap when db lowered below count
      start(8'd3, 8'd5, '0);
      ticks(4);
      chk("R1 before lowering db", data_out, 0);
      wr(AD_DB, 8'd2);
      ticks(253);
      chk("R13 no match before wrap", db_flag, 0);
      chk("R13 still inactive", data_out, 0);
      ticks(1);
      chk("R13 match after wrap", db_flag, 1);
      chk("R13 symbol restarts", data_out, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule